// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Output Latency

This block is a first-in first-out buffer with one clock. A producer pushes words with a write enable and a consumer pops them with a read enable. Both sides see a full flag, an empty flag and a count of stored words. Two compile-time parameters shape the read side, and each can be set without regard to the other. `SHOW_AHEAD` selects between two read styles. With it cleared, a word is delivered on the read-data port one clock after it is requested. With it set, the oldest word is already on the read-data port whenever empty is low, and a read enable only advances to the next word. `OUT_REG` says whether a register sits after the storage array.

The two parameters together fix how many clocks pass before a word written into an empty buffer becomes visible to the reader. The full flag and the word count respond to every accepted request in exactly one clock, in all four combinations. Storage is an ordinary register array. The reset is synchronous.

Top module: `sync_fifo_lat`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `empty` is 1, `full` is 0 and `level` is 0. With `SHOW_AHEAD`=0 or `OUT_REG`=1, `rd_data` is 0 after reset.
- R2: `full` goes high one clock after the accepted write that brings the stored count to `DEPTH`. It goes low one clock after an accepted read from a full buffer.
- R3: `level` changes one clock after each accepted request: +1 for a write alone, -1 for a read alone. It is unchanged when a write and a read are both accepted in the same cycle.
- R4: A write while `full` is 1 is dropped and a read while `empty` is 1 is dropped. In both cases `level` and the stored contents are unchanged.
- R5: After a write into an empty buffer, `empty` falls this many clocks later: 1 with both parameters 0, 2 with `SHOW_AHEAD`=0 and `OUT_REG`=1, 2 with `SHOW_AHEAD`=1 and `OUT_REG`=0, and 3 with both parameters 1.
- R6: An accepted read that takes the last visible word raises `empty` one clock later, in every parameter combination.
- R7: With `SHOW_AHEAD`=0, an accepted read puts the popped word on `rd_data` one clock later. `rd_data` then holds that word until the next accepted read.
- R8: With `SHOW_AHEAD`=1, whenever `empty` is 0, `rd_data` equals the oldest stored word. It appears in the same clock that `empty` falls and changes one clock after an accepted read.
- R9: Words leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Delivered word (normal) or head word (show-ahead) |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | No word is visible to the reader |
| level | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
Two events can fall in the same cycle. A read can take the last visible word while a write lands in an empty or draining buffer. A write can also arrive while a read frees a slot in a full buffer. These cases are provoked by directed runs held at `level` DEPTH and at mid-level, and by random phases that tilt the write probability towards filling and then towards draining. All four parameter combinations run side by side on the same inputs. Each is judged every cycle against a bench model of stored words, visible words and the pending-visibility pipeline: `level` must hold on a double request, the dropped side of a request must leave the count intact, and `empty` must fall at the clock set by R5 for that combination.

// File: rtl/sync_fifo_lat_pkg.sv
package sync_fifo_lat_pkg;

    // Pair of request strobes after acceptance gating.
    typedef struct packed {
        logic wr;
        logic rd;
    } xfer_t;

    // Extra clocks a fresh write waits before the reader may see it,
    // on top of the one clock every registered flag already takes.
    function automatic int unsigned vis_delay(bit show_ahead, bit out_reg);
        return (show_ahead ? 1 : 0) + (out_reg ? 1 : 0);
    endfunction

    function automatic int unsigned addr_bits(int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/sync_fifo_lat_ctrl.sv
module sync_fifo_lat_ctrl
    import sync_fifo_lat_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DLY   = 1,
    localparam int unsigned AW   = addr_bits(DEPTH),
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output xfer_t         acc,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] rd_ptr_nxt,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [LW-1:0] stored_q;
    logic [LW-1:0] visible_q;
    logic          wr_seen;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full      = (stored_q == LW'(DEPTH));
    assign empty     = (visible_q == '0);
    assign level     = stored_q;
    assign acc.wr    = wr_en & ~full;
    assign acc.rd    = rd_en & ~empty;
    assign rd_ptr_nxt = acc.rd ? bump(rd_ptr) : rd_ptr;

    // Visibility delay line for accepted writes.
    generate
        if (DLY == 0) begin : g_nodly
            assign wr_seen = acc.wr;
        end else begin : g_dly
            logic [DLY-1:0] pipe_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q[0] <= acc.wr;
                    for (int i = 1; i < DLY; i++) begin
                        pipe_q[i] <= pipe_q[i-1];
                    end
                end
            end
            assign wr_seen = pipe_q[DLY-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            stored_q  <= '0;
            visible_q <= '0;
        end else begin
            if (acc.wr) wr_ptr <= bump(wr_ptr);
            rd_ptr <= rd_ptr_nxt;
            case (acc)
                2'b10:   stored_q <= stored_q + LW'(1);
                2'b01:   stored_q <= stored_q - LW'(1);
                default: stored_q <= stored_q;
            endcase
            visible_q <= visible_q + LW'(wr_seen) - LW'(acc.rd);
        end
    end

endmodule

// File: rtl/sync_fifo_lat_store.sv
module sync_fifo_lat_store
    import sync_fifo_lat_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned DEPTH      = 8,
    parameter bit          SHOW_AHEAD = 1'b0,
    parameter bit          OUT_REG    = 1'b1,
    localparam int unsigned AW        = addr_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  xfer_t            acc,
    input  logic [AW-1:0]    wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_ptr,
    input  logic [AW-1:0]    rd_ptr_nxt,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (acc.wr) mem[wr_ptr] <= wr_data;
    end

    generate
        if (!SHOW_AHEAD) begin : g_normal
            logic [WIDTH-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst)         q_r <= '0;
                else if (acc.rd) q_r <= mem[rd_ptr];
            end
            assign rd_data = q_r;
        end else if (OUT_REG) begin : g_ahead_reg
            logic [WIDTH-1:0] q_r;
            always_ff @(posedge clk) begin
                if (rst)
                    q_r <= '0;
                else if (acc.wr && (wr_ptr == rd_ptr_nxt))
                    q_r <= wr_data;
                else
                    q_r <= mem[rd_ptr_nxt];
            end
            assign rd_data = q_r;
        end else begin : g_ahead_comb
            assign rd_data = mem[rd_ptr];
        end
    endgenerate

endmodule

// File: rtl/sync_fifo_lat.sv
module sync_fifo_lat
    import sync_fifo_lat_pkg::*;
#(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned DEPTH      = 8,
    parameter bit          SHOW_AHEAD = 1'b0,
    parameter bit          OUT_REG    = 1'b1,
    localparam int unsigned AW        = addr_bits(DEPTH),
    localparam int unsigned LW        = $clog2(DEPTH + 1),
    localparam int unsigned DLY       = vis_delay(SHOW_AHEAD, OUT_REG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic [LW-1:0]    level
);

    xfer_t         acc;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] rd_ptr_nxt;

    sync_fifo_lat_ctrl #(
        .DEPTH (DEPTH),
        .DLY   (DLY)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .acc        (acc),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .rd_ptr_nxt (rd_ptr_nxt),
        .level      (level),
        .full       (full),
        .empty      (empty)
    );

    sync_fifo_lat_store #(
        .WIDTH      (WIDTH),
        .DEPTH      (DEPTH),
        .SHOW_AHEAD (SHOW_AHEAD),
        .OUT_REG    (OUT_REG)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .wr_ptr     (wr_ptr),
        .wr_data    (wr_data),
        .rd_ptr     (rd_ptr),
        .rd_ptr_nxt (rd_ptr_nxt),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/sync_fifo_lat_chk.sv
module sync_fifo_lat_chk #(
    parameter int unsigned WIDTH      = 8,
    parameter int unsigned DEPTH      = 8,
    parameter bit          SHOW_AHEAD = 1'b0,
    localparam int unsigned LW        = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] rd_data,
    input logic             full,
    input logic             empty,
    input logic [LW-1:0]    level
);

    p_level_step_r3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (level == $past(level)) || (level == $past(level) + LW'(1))
                 || (level == $past(level) - LW'(1)));

    p_rw_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !full && !empty) |=> $stable(level));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en) |=> $stable(level));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (empty && rd_en && !wr_en) |=> $stable(level));

    p_full_set_r2: assert property (@(posedge clk) disable iff (rst)
        (level == LW'(DEPTH - 1) && wr_en && !rd_en) |=> full);

    p_stay_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && !wr_en) |=> empty);

    p_last_read_r6: assert property (@(posedge clk) disable iff (rst)
        (!empty && rd_en && !wr_en && level == LW'(1)) |=> empty);

    generate
        if (SHOW_AHEAD) begin : g_sa
            p_head_hold_r8: assert property (@(posedge clk) disable iff (rst)
                (!empty && !rd_en) |=> (!empty && $stable(rd_data)));
        end else begin : g_nm
            p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
                (!rd_en || empty) |=> $stable(rd_data));
        end
    endgenerate

endmodule

bind sync_fifo_lat sync_fifo_lat_chk #(
    .WIDTH      (WIDTH),
    .DEPTH      (DEPTH),
    .SHOW_AHEAD (SHOW_AHEAD)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .full    (full),
    .empty   (empty),
    .level   (level)
);

// File: tb/test_sync_fifo_lat.sv
module test_sync_fifo_lat;

    localparam int W  = 8;
    localparam int D  = 8;
    localparam int NI = 4;
    // instance 0: normal/reg, 1: normal/no reg, 2: show-ahead/no reg, 3: show-ahead/reg
    localparam int SA_OF[NI]  = '{0, 0, 1, 1};
    localparam int DLY_OF[NI] = '{1, 0, 1, 2};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;

    logic [W-1:0] q_o   [NI];
    logic         full_o [NI];
    logic         empty_o[NI];
    logic [3:0]   lvl_o  [NI];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sync_fifo_lat #(.WIDTH(W), .DEPTH(D), .SHOW_AHEAD(1'b0), .OUT_REG(1'b1)) i_sync_fifo_lat (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(q_o[0]), .full(full_o[0]), .empty(empty_o[0]), .level(lvl_o[0]));
    sync_fifo_lat #(.WIDTH(W), .DEPTH(D), .SHOW_AHEAD(1'b0), .OUT_REG(1'b0)) i_sync_fifo_lat_na (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(q_o[1]), .full(full_o[1]), .empty(empty_o[1]), .level(lvl_o[1]));
    sync_fifo_lat #(.WIDTH(W), .DEPTH(D), .SHOW_AHEAD(1'b1), .OUT_REG(1'b0)) i_sync_fifo_lat_sa (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(q_o[2]), .full(full_o[2]), .empty(empty_o[2]), .level(lvl_o[2]));
    sync_fifo_lat #(.WIDTH(W), .DEPTH(D), .SHOW_AHEAD(1'b1), .OUT_REG(1'b1)) i_sync_fifo_lat_sr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(q_o[3]), .full(full_o[3]), .empty(empty_o[3]), .level(lvl_o[3]));

    // Reference model state, one set per instance.
    int           m_head[NI];
    int           m_cnt [NI];
    int           m_vis [NI];
    bit           m_pipe[NI][3];
    logic [W-1:0] m_mem [NI][D];
    logic [W-1:0] m_last[NI];

    function automatic void check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    function automatic void model_reset();
        for (int k = 0; k < NI; k++) begin
            m_head[k] = 0; m_cnt[k] = 0; m_vis[k] = 0; m_last[k] = '0;
            for (int i = 0; i < 3; i++) m_pipe[k][i] = 1'b0;
        end
    endfunction

    function automatic void model_step(int k, bit wr, bit rd, logic [W-1:0] d);
        bit wa, ra, ws;
        wa = wr && (m_cnt[k] != D);
        ra = rd && (m_vis[k] != 0);
        ws = (DLY_OF[k] == 0) ? wa : m_pipe[k][DLY_OF[k]-1];
        for (int i = 2; i > 0; i--) m_pipe[k][i] = m_pipe[k][i-1];
        m_pipe[k][0] = wa;
        if (ra) begin
            m_last[k] = m_mem[k][m_head[k]];
            m_head[k] = (m_head[k] + 1) % D;
            m_cnt[k]--;
        end
        if (wa) begin
            m_mem[k][(m_head[k] + m_cnt[k]) % D] = d;
            m_cnt[k]++;
        end
        m_vis[k] = m_vis[k] + int'(ws) - int'(ra);
    endfunction

    function automatic void compare_all();
        for (int k = 0; k < NI; k++) begin
            check(full_o[k] == (m_cnt[k] == D), "R2", $sformatf("full inst%0d", k),
                  int'(full_o[k]), int'(m_cnt[k] == D));
            check(int'(lvl_o[k]) == m_cnt[k], "R3", $sformatf("level inst%0d", k),
                  int'(lvl_o[k]), m_cnt[k]);
            check(empty_o[k] == (m_vis[k] == 0), "R5/R6", $sformatf("empty inst%0d", k),
                  int'(empty_o[k]), int'(m_vis[k] == 0));
            if (SA_OF[k] == 0)
                check(q_o[k] == m_last[k], "R7", $sformatf("data inst%0d", k),
                      int'(q_o[k]), int'(m_last[k]));
            else if (m_vis[k] != 0)
                check(q_o[k] == m_mem[k][m_head[k]], "R8", $sformatf("head inst%0d", k),
                      int'(q_o[k]), int'(m_mem[k][m_head[k]]));
        end
    endfunction

    // One clock: drive at the falling edge, model after the rising edge, compare at the next falling edge.
    task automatic cycle(bit wr, bit rd, logic [W-1:0] d);
        wr_en = wr; rd_en = rd; wr_data = d;
        @(posedge clk);
        if (rst) model_reset();
        else for (int k = 0; k < NI; k++) model_step(k, wr, rd, d);
        @(negedge clk);
        if (!rst) compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycle(1'b0, 1'b0, '0);
        cycle(1'b0, 1'b0, '0);
        rst = 1'b0;
        for (int k = 0; k < NI; k++) begin
            check(empty_o[k] == 1'b1, "R1", $sformatf("empty after reset inst%0d", k), int'(empty_o[k]), 1);
            check(full_o[k] == 1'b0, "R1", $sformatf("full after reset inst%0d", k), int'(full_o[k]), 0);
            check(lvl_o[k] == '0, "R1", $sformatf("level after reset inst%0d", k), int'(lvl_o[k]), 0);
            if (k != 2)
                check(q_o[k] == '0, "R1", $sformatf("data after reset inst%0d", k), int'(q_o[k]), 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int fall_at[NI];
        model_reset();
        @(negedge clk);
        do_reset();

        // R5: write one word into the empty buffer, measure when empty falls.
        for (int k = 0; k < NI; k++) fall_at[k] = 0;
        cycle(1'b1, 1'b0, 8'h5A);
        for (int n = 1; n <= 4; n++) begin
            for (int k = 0; k < NI; k++)
                if (fall_at[k] == 0 && !empty_o[k]) fall_at[k] = n;
            if (n < 4) cycle(1'b0, 1'b0, '0);
        end
        for (int k = 0; k < NI; k++)
            check(fall_at[k] == DLY_OF[k] + 1, "R5", $sformatf("empty latency inst%0d", k),
                  fall_at[k], DLY_OF[k] + 1);

        // R6: read the only word; empty rises one clock later everywhere.
        cycle(1'b0, 1'b1, '0);
        for (int k = 0; k < NI; k++)
            check(empty_o[k] == 1'b1, "R6", $sformatf("empty after last read inst%0d", k), int'(empty_o[k]), 1);
        check(q_o[0] == 8'h5A, "R7", "popped word", int'(q_o[0]), 'h5A);

        // R4: read while empty is dropped.
        cycle(1'b0, 1'b1, '0);
        check(lvl_o[0] == 4'd0, "R4", "level after read on empty", int'(lvl_o[0]), 0);

        // R4, R2: overfill by two.
        for (int i = 0; i < 10; i++) cycle(1'b1, 1'b0, 8'hA0 + 8'(i));
        check(lvl_o[0] == 4'd8, "R4", "level after overfill", int'(lvl_o[0]), 8);
        check(full_o[3] == 1'b1, "R2", "full after overfill", int'(full_o[3]), 1);
        cycle(1'b0, 1'b0, '0);
        cycle(1'b0, 1'b0, '0);
        cycle(1'b0, 1'b0, '0);

        // R9: drain in order on the normal registered instance.
        for (int i = 0; i < 8; i++) begin
            cycle(1'b0, 1'b1, '0);
            check(q_o[0] == 8'hA0 + 8'(i), "R9", "drain order", int'(q_o[0]), 'hA0 + i);
        end

        // R3: simultaneous read and write at mid level.
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, 8'h30 + 8'(i));
        repeat (3) cycle(1'b0, 1'b0, '0);
        for (int i = 0; i < 6; i++) begin
            cycle(1'b1, 1'b1, 8'h40 + 8'(i));
            check(lvl_o[1] == 4'd4, "R3", "level on double request", int'(lvl_o[1]), 4);
        end

        // Full plus read plus write in the same cycle.
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 8'h50 + 8'(i));
        repeat (3) cycle(1'b0, 1'b0, '0);
        cycle(1'b1, 1'b1, 8'hEE);
        check(lvl_o[0] == 4'd7, "R4", "write on full dropped while read taken", int'(lvl_o[0]), 7);

        // Random phases with a fixed seed.
        begin
            int unsigned seed = 32'd12345;
            void'($urandom(seed));
            for (int ph = 0; ph < 30; ph++) begin
                int unsigned wp = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
                int unsigned rp = (ph % 3 == 0) ? 25 : (ph % 3 == 1) ? 80 : 50;
                for (int c = 0; c < 100; c++) begin
                    bit w = ($urandom % 100) < wp;
                    bit r = ($urandom % 100) < rp;
                    if (($urandom % 600) == 0) do_reset();
                    cycle(w, r, 8'($urandom));
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule